// File: doc/BRIEF.md
# Video Memory DMA Controller

This block feeds the video memory write port without help from the host processor. Software first programs a small set of configuration registers: the transfer length, the source location and the transfer kind. It then issues an access command that carries a destination address and a DMA flag. Each word the block produces leaves through a single registered write port. The destination pointer advances after every write by the programmed auto-increment step.

Three transfer kinds exist. An external burst reads byte pairs from the system bus through a request/acknowledge interface. An internal copy reads byte pairs from video RAM itself. A fill does nothing when the command arrives: it waits for the next host data write and then repeats that value once per counted unit. Ordinary host data writes made outside a DMA use the same write port and the same auto-increment. While a transfer runs, the block raises busy and stalls the host's data port.

Top module: `vdma_engine`

## Requirements
- R1: After reset, busy, hostStall, wrEn, extReq and vramRd are all low.
- R2: The first source byte address of a transfer is {reg 0x17[6:0], reg 0x16, reg 0x15, 1'b0}, a 24-bit even address.
- R3: The transfer length is the 16-bit word count {reg 0x14, reg 0x13}, and a transfer performs exactly that many writes.
- R4: Bits 7:6 of reg 0x17 select the kind when a command with the DMA flag arrives: 00 or 01 external burst, 10 fill, 11 video RAM copy.
- R5: In an external burst, each byte is fetched with a one-cycle extReq pulse, and the block waits for extAck before taking extData. The source address rises by one per byte, and each word is {first byte, second byte}.
- R6: In a copy, bytes are read from video RAM at the source address truncated to 16 bits, so the address wraps from 0xFFFF to 0x0000. The first byte of each pair forms the high byte.
- R7: A fill makes no write when its command arrives. The next host data write repeats hostData length times, and each repeated write carries that write's hostByte flag (1 = only bits 7:0 are meaningful).
- R8: A command loads the destination pointer from cmdAddr. After every write, including plain host writes, the pointer advances by reg 0x0F modulo 2^16.
- R9: busy rises in the cycle after a transfer starts and stays high through the cycle in which the last write is visible on wrEn. hostStall equals busy.
- R10: A zero length performs no writes and busy never rises. A fill armed with zero length consumes the next host write without writing.
- R11: A host data write made while no fill is armed produces exactly one write of hostData and hostByte on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Configuration register write strobe |
| regAddr | input | 5 | Configuration register index |
| regData | input | 8 | Configuration register value |
| cmdValid | input | 1 | Access command completed this cycle |
| cmdAddr | input | 16 | Destination address carried by the command |
| cmdDma | input | 1 | Command requests a DMA |
| hostWe | input | 1 | Host data-port write |
| hostByte | input | 1 | Host write is a byte (low 8 bits) |
| hostData | input | 16 | Host write data |
| hostStall | output | 1 | Host data port must hold off |
| extReq | output | 1 | External byte read request pulse |
| extAddr | output | 24 | External byte address |
| extAck | input | 1 | External byte ready |
| extData | input | 8 | External byte |
| vramRd | output | 1 | Video RAM byte read, data valid next cycle |
| vramAddr | output | 16 | Video RAM read address |
| vramData | input | 8 | Video RAM read byte |
| wrEn | output | 1 | Write port strobe |
| wrAddr | output | 16 | Write port address |
| wrData | output | 16 | Write port data |
| wrByte | output | 1 | Write is a byte write |
| busy | output | 1 | Transfer in progress |

## Verification
The bench uses the default widths: 8-bit registers, a 16-bit length and a 16-bit destination and video RAM address. At these widths a copy that starts at 0xFFFC reaches the 16-bit source wrap within a few words. An auto-increment near 255 pushes the destination pointer through its own wrap. Setting bit 6 of reg 0x17 selects external mode 01 and also sets source bit 23, so the two meanings of that shared bit are checked against each other. Random acknowledge delays of one to three cycles exercise the wait on extAck.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam logic [4:0] REG_STEP   = 5'h0F;
  localparam logic [4:0] REG_LEN_LO = 5'h13;
  localparam logic [4:0] REG_LEN_HI = 5'h14;
  localparam logic [4:0] REG_SRC_LO = 5'h15;
  localparam logic [4:0] REG_SRC_MD = 5'h16;
  localparam logic [4:0] REG_SRC_HI = 5'h17;

  localparam logic [1:0] KIND_FILL = 2'b10;
  localparam logic [1:0] KIND_COPY = 2'b11;

  typedef struct packed {
    logic loadCmd;
    logic loadFill;
    logic passHost;
    logic capHi;
    logic capLo;
    logic emitWord;
    logic emitFill;
    logic selCopy;
  } dmaCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_HI, ST_WT_HI, ST_RD_LO, ST_WT_LO, ST_EMIT, ST_FILL, ST_TAIL
  } dmaState_e;
endpackage

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdDma,
  input  logic       hostWe,
  input  logic       extAck,
  input  logic [1:0] cfgKind,
  input  logic       cfgLenZero,
  input  logic       cntZero,
  input  logic       cntOne,
  output dmaCtl_t    ctl,
  output logic       extReq,
  output logic       vramRd,
  output logic       busy
);
  dmaState_e state, nextState;
  logic armed, useCopy;

  always_comb begin
    ctl = '0;
    ctl.selCopy = useCopy;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          ctl.loadCmd = 1'b1;
          if (cmdDma && cfgKind != KIND_FILL && !cfgLenZero) nextState = ST_RD_HI;
        end else if (hostWe) begin
          if (armed) begin
            ctl.loadFill = 1'b1;
            if (!cntZero) nextState = ST_FILL;
          end else begin
            ctl.passHost = 1'b1;
          end
        end
      end
      ST_RD_HI: nextState = ST_WT_HI;
      ST_WT_HI: if (useCopy || extAck) begin
        ctl.capHi = 1'b1;
        nextState = ST_RD_LO;
      end
      ST_RD_LO: nextState = ST_WT_LO;
      ST_WT_LO: if (useCopy || extAck) begin
        ctl.capLo = 1'b1;
        nextState = ST_EMIT;
      end
      ST_EMIT: begin
        ctl.emitWord = 1'b1;
        nextState = cntOne ? ST_TAIL : ST_RD_HI;
      end
      ST_FILL: begin
        ctl.emitFill = 1'b1;
        if (cntOne) nextState = ST_TAIL;
      end
      ST_TAIL: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      armed   <= 1'b0;
      useCopy <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.loadCmd) begin
        armed   <= cmdDma && (cfgKind == KIND_FILL);
        useCopy <= (cfgKind == KIND_COPY);
      end else if (ctl.loadFill) begin
        armed <= 1'b0;
      end
    end
  end

  assign extReq = !useCopy && (state == ST_RD_HI || state == ST_RD_LO);
  assign vramRd =  useCopy && (state == ST_RD_HI || state == ST_RD_LO);
  assign busy   = (state != ST_IDLE);

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    extReq |=> !extReq); // R5
  AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdValid && cmdDma && cfgLenZero) |=> !busy); // R10
  AST_TAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TAIL) |-> $past(ctl.emitWord || ctl.emitFill)); // R9
endmodule

// File: rtl/vdma_datapath.sv
module vdma_datapath
  import vdma_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DST_W  = 16,
  parameter int RA_W   = 5,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int LEN_W  = 2 * BYTE_W,
  localparam int SRC_W  = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [BYTE_W-1:0] regData,
  input  logic [DST_W-1:0]  cmdAddr,
  input  logic              hostByte,
  input  logic [WORD_W-1:0] hostData,
  input  logic [BYTE_W-1:0] extData,
  input  logic [BYTE_W-1:0] vramData,
  input  dmaCtl_t           ctl,
  output logic [1:0]        cfgKind,
  output logic              cfgLenZero,
  output logic              cntZero,
  output logic              cntOne,
  output logic [SRC_W-1:0]  srcAddr,
  output logic              wrEn,
  output logic [DST_W-1:0]  wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              wrByte
);
  logic [BYTE_W-1:0] stepReg, lenLo, lenHi, srcLo, srcMd, srcHi;
  logic [LEN_W-1:0]  count;
  logic [DST_W-1:0]  dest;
  logic [BYTE_W-1:0] hiByte, loByte, capByte;
  logic [WORD_W-1:0] fillData;
  logic              fillByte;
  logic              anyWrite;

  assign cfgKind    = srcHi[BYTE_W-1 -: 2];
  assign cfgLenZero = ({lenHi, lenLo} == '0);
  assign cntZero    = (count == '0);
  assign cntOne     = (count == LEN_W'(1));
  assign capByte    = ctl.selCopy ? vramData : extData;
  assign anyWrite   = ctl.emitWord || ctl.emitFill || ctl.passHost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepReg <= '0; lenLo <= '0; lenHi <= '0;
      srcLo <= '0; srcMd <= '0; srcHi <= '0;
    end else if (regWe) begin
      unique case (regAddr)
        REG_STEP:   stepReg <= regData;
        REG_LEN_LO: lenLo   <= regData;
        REG_LEN_HI: lenHi   <= regData;
        REG_SRC_LO: srcLo   <= regData;
        REG_SRC_MD: srcMd   <= regData;
        REG_SRC_HI: srcHi   <= regData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0; count <= '0; dest <= '0;
      hiByte <= '0; loByte <= '0; fillData <= '0; fillByte <= 1'b0;
      wrEn <= 1'b0; wrAddr <= '0; wrData <= '0; wrByte <= 1'b0;
    end else begin
      if (ctl.loadCmd) begin
        srcAddr <= {srcHi[BYTE_W-2:0], srcMd, srcLo, 1'b0};
        count   <= {lenHi, lenLo};
        dest    <= cmdAddr;
      end else begin
        if (ctl.capHi || ctl.capLo) srcAddr <= srcAddr + SRC_W'(1);
        if (ctl.emitWord || ctl.emitFill) count <= count - LEN_W'(1);
        if (anyWrite) dest <= dest + DST_W'(stepReg);
      end
      if (ctl.capHi) hiByte <= capByte;
      if (ctl.capLo) loByte <= capByte;
      if (ctl.loadFill) begin
        fillData <= hostData;
        fillByte <= hostByte;
      end
      wrEn <= anyWrite;
      if (anyWrite) begin
        wrAddr <= dest;
        if (ctl.emitWord) begin
          wrData <= {hiByte, loByte};
          wrByte <= 1'b0;
        end else if (ctl.emitFill) begin
          wrData <= fillData;
          wrByte <= fillByte;
        end else begin
          wrData <= hostData;
          wrByte <= hostByte;
        end
      end
    end
  end

  AST_SRC_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCmd |=> !srcAddr[0]); // R2
  AST_EMIT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emitWord || ctl.emitFill) |-> !cntZero); // R3
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DST_W  = 16,
  parameter int RA_W   = 5,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int SRC_W  = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [BYTE_W-1:0] regData,
  input  logic              cmdValid,
  input  logic [DST_W-1:0]  cmdAddr,
  input  logic              cmdDma,
  input  logic              hostWe,
  input  logic              hostByte,
  input  logic [WORD_W-1:0] hostData,
  output logic              hostStall,
  output logic              extReq,
  output logic [SRC_W-1:0]  extAddr,
  input  logic              extAck,
  input  logic [BYTE_W-1:0] extData,
  output logic              vramRd,
  output logic [DST_W-1:0]  vramAddr,
  input  logic [BYTE_W-1:0] vramData,
  output logic              wrEn,
  output logic [DST_W-1:0]  wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              wrByte,
  output logic              busy
);
  dmaCtl_t          ctl;
  logic [1:0]       cfgKind;
  logic             cfgLenZero, cntZero, cntOne;
  logic [SRC_W-1:0] srcAddr;

  vdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdDma(cmdDma),
    .hostWe(hostWe), .extAck(extAck), .cfgKind(cfgKind),
    .cfgLenZero(cfgLenZero), .cntZero(cntZero), .cntOne(cntOne),
    .ctl(ctl), .extReq(extReq), .vramRd(vramRd), .busy(busy)
  );

  vdma_datapath #(.BYTE_W(BYTE_W), .DST_W(DST_W), .RA_W(RA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regData(regData), .cmdAddr(cmdAddr), .hostByte(hostByte),
    .hostData(hostData), .extData(extData), .vramData(vramData),
    .ctl(ctl), .cfgKind(cfgKind), .cfgLenZero(cfgLenZero),
    .cntZero(cntZero), .cntOne(cntOne), .srcAddr(srcAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrByte(wrByte)
  );

  assign extAddr   = srcAddr;
  assign vramAddr  = srcAddr[DST_W-1:0];
  assign hostStall = busy;
endmodule

// File: tb/vdma_engine_bench.sv
`timescale 1ns/1ps
module vdma_engine_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic cmdValid = 1'b0, cmdDma = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic hostWe = 1'b0, hostByte = 1'b0;
  logic [15:0] hostData = '0;
  logic hostStall, extReq, vramRd, wrEn, wrByte, busy;
  logic [23:0] extAddr;
  logic [15:0] vramAddr, wrAddr, wrData;
  logic extAck = 1'b0;
  logic [7:0] extData = '0;
  logic [7:0] vramData = '0;

  always #2 clk = ~clk;

  vdma_engine u_vdma_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdDma(cmdDma),
    .hostWe(hostWe), .hostByte(hostByte), .hostData(hostData),
    .hostStall(hostStall), .extReq(extReq), .extAddr(extAddr),
    .extAck(extAck), .extData(extData), .vramRd(vramRd), .vramAddr(vramAddr),
    .vramData(vramData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrByte(wrByte), .busy(busy)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  function automatic logic [7:0] extByteOf(logic [23:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] vramByteOf(logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hC3;
  endfunction

  // observation logs
  logic [15:0] logAddr [64];
  logic [15:0] logData [64];
  logic        logByte [64];
  logic [23:0] reqLog  [64];
  int nLog, nReq, busyLowWrites, busySeen, stallMismatch, reqDouble;
  int pendCnt = 0;
  logic [23:0] pendAddr;
  logic prevReq = 1'b0;

  always @(negedge clk) begin
    if (wrEn) begin
      if (nLog < 64) begin
        logAddr[nLog] = wrAddr; logData[nLog] = wrData; logByte[nLog] = wrByte;
      end
      nLog++;
      if (!busy) busyLowWrites++;
    end
    if (busy) busySeen++;
    if (hostStall !== busy) stallMismatch++;
    // external byte responder
    extAck = 1'b0;
    if (pendCnt == 1) begin
      extAck = 1'b1; extData = extByteOf(pendAddr); pendCnt = 0;
    end else if (pendCnt > 1) pendCnt--;
    if (extReq) begin
      if (prevReq) reqDouble++;
      if (nReq < 64) reqLog[nReq] = extAddr;
      nReq++;
      pendAddr = extAddr;
      pendCnt = 1 + int'($urandom % 3);
    end
    prevReq = extReq;
    if (vramRd) begin
      if (nReq < 64) reqLog[nReq] = {8'h00, vramAddr};
      nReq++;
      vramData = vramByteOf(vramAddr);
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    nLog = 0; nReq = 0; busyLowWrites = 0; busySeen = 0; reqDouble = 0;
  endtask

  task automatic setReg(logic [4:0] a, logic [7:0] d);
    regAddr = a; regData = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic command(logic [15:0] a, logic dma);
    cmdAddr = a; cmdDma = dma; cmdValid = 1'b1;
    @(negedge clk); cmdValid = 1'b0; cmdDma = 1'b0;
  endtask

  task automatic hostWrite(logic [15:0] d, logic isByte);
    hostData = d; hostByte = isByte; hostWe = 1'b1;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) check(0, "R9 busy timeout", n, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic runTransfer(logic [1:0] kind, logic [7:0] s15, logic [7:0] s16,
                             logic [5:0] s17lo, int len, logic [15:0] dest,
                             logic [7:0] step, logic [15:0] fillVal, logic fillB);
    logic [7:0] r17;
    logic [23:0] src;
    logic [15:0] expAddr, expData;
    bit startBusy;
    r17 = {kind, s17lo};
    src = {r17[6:0], s16, s15, 1'b0};
    setReg(5'h0F, step);
    setReg(5'h13, len[7:0]);
    setReg(5'h14, len[15:8]);
    setReg(5'h15, s15);
    setReg(5'h16, s16);
    setReg(5'h17, r17);
    clearLog();
    command(dest, 1'b1);
    startBusy = busy;
    if (kind == 2'b10) begin
      repeat (3) @(negedge clk);
      check(nLog == 0 && busySeen == 0, "R7 fill idle until host write", nLog, 0);
      hostWrite(fillVal, fillB);
      startBusy = busy;
    end
    waitIdle();
    check(nLog == len, "R3 write count", nLog, len);
    if (len == 0) check(busySeen == 0, "R10 zero length busy", busySeen, 0);
    else check(startBusy, "R9 busy after start", startBusy, 1);
    check(busyLowWrites == 0, "R9 busy covers writes", busyLowWrites, 0);
    check(stallMismatch == 0, "R9 stall equals busy", stallMismatch, 0);
    for (int k = 0; k < len && k < nLog && k < 32; k++) begin
      expAddr = dest + 16'(k * int'(step));
      check(logAddr[k] == expAddr, "R8 destination", logAddr[k], expAddr);
      if (kind == 2'b10) begin
        check(logData[k] == fillVal && logByte[k] == fillB, "R7 fill value",
              {logByte[k], logData[k]}, {fillB, fillVal});
      end else if (kind == 2'b11) begin
        expData = {vramByteOf(16'(src + 24'(2*k))), vramByteOf(16'(src + 24'(2*k + 1)))};
        check(logData[k] == expData && !logByte[k], "R6 copy word", logData[k], expData);
      end else begin
        expData = {extByteOf(src + 24'(2*k)), extByteOf(src + 24'(2*k + 1))};
        check(logData[k] == expData && !logByte[k], "R5 external word", logData[k], expData);
      end
    end
    if (kind != 2'b10) begin
      check(nReq == 2*len, "R4 read count for kind", nReq, 2*len);
      for (int j = 0; j < nReq && j < 2*len && j < 64; j++) begin
        if (kind == 2'b11)
          check(reqLog[j] == {8'h00, 16'(src + 24'(j))}, "R6 video RAM address",
                reqLog[j], 16'(src + 24'(j)));
        else if (j == 0)
          check(reqLog[j] == src, "R2 first source address", reqLog[j], src);
        else
          check(reqLog[j] == src + 24'(j), "R5 source step", reqLog[j], src + 24'(j));
      end
      check(reqDouble == 0, "R5 request pulse width", reqDouble, 0);
    end else begin
      check(nReq == 0, "R4 fill reads nothing", nReq, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    stallMismatch = 0;
    clearLog();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !hostStall && !wrEn && !extReq && !vramRd, "R1 reset outputs",
          {busy, hostStall, wrEn, extReq, vramRd}, 0);

    // R11 and R8: plain host writes with auto-increment
    setReg(5'h0F, 8'h02);
    clearLog();
    command(16'h1230, 1'b0);
    hostWrite(16'hBEEF, 1'b0);
    hostWrite(16'h00A5, 1'b1);
    repeat (2) @(negedge clk);
    check(nLog == 2, "R11 host write count", nLog, 2);
    check(logAddr[0] == 16'h1230 && logAddr[1] == 16'h1232, "R8 host step",
          logAddr[1], 16'h1232);
    check(logData[0] == 16'hBEEF && !logByte[0], "R11 host word", logData[0], 16'hBEEF);
    check(logData[1] == 16'h00A5 && logByte[1], "R11 host byte", logData[1], 16'h00A5);

    // directed transfers
    runTransfer(2'b00, 8'h34, 8'h12, 6'h05, 4, 16'h0100, 8'h02, '0, 0);    // R4 kind 00
    runTransfer(2'b01, 8'hFF, 8'hFF, 6'h3F, 3, 16'hFFFE, 8'hFF, '0, 0);    // R4 kind 01, R8 wrap
    runTransfer(2'b11, 8'hFE, 8'h7F, 6'h00, 3, 16'h4000, 8'h02, '0, 0);    // R6 wrap
    runTransfer(2'b10, 8'h00, 8'h00, 6'h00, 5, 16'h2000, 8'h02, 16'hCAFE, 0); // R7 word
    runTransfer(2'b10, 8'h00, 8'h00, 6'h00, 3, 16'h2001, 8'h01, 16'h0077, 1); // R7 byte
    runTransfer(2'b00, 8'h10, 8'h20, 6'h01, 2, 16'h0800, 8'h00, '0, 0);    // R8 step zero
    runTransfer(2'b00, 8'h10, 8'h20, 6'h01, 0, 16'h0800, 8'h02, '0, 0);    // R10 external
    runTransfer(2'b11, 8'h10, 8'h20, 6'h01, 0, 16'h0800, 8'h02, '0, 0);    // R10 copy
    runTransfer(2'b10, 8'h00, 8'h00, 6'h00, 0, 16'h0900, 8'h02, 16'h1111, 0); // R10 fill

    // after a zero fill, the next host write is a plain write (R10, R11)
    clearLog();
    hostWrite(16'h2222, 1'b0);
    repeat (2) @(negedge clk);
    check(nLog == 1 && logData[0] == 16'h2222 && logAddr[0] == 16'h0900,
          "R11 write after zero fill", logData[0], 16'h2222);

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [1:0] kind;
      kind = 2'($urandom % 4);
      runTransfer(kind, 8'($urandom), 8'($urandom), 6'($urandom),
                  int'($urandom % 7), 16'($urandom), 8'($urandom),
                  16'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired R9 actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule